// File: doc/BRIEF.md
# Set Controller for a Cache with Data-less Ways

This block manages a single set of a 16-way inclusive last-level cache in which not every way has data storage. Each way stores a tag and a coherence state. The two lowest-numbered ways never have data storage. A runtime count, `dis_cnt`, switches off the data storage of further ways, starting at way 2 and counting upward. Ways without data are called the data-less class, and all other ways are called the data-capable class. A block whose up-to-date copy lives in a private cache is kept as a tag in a data-less way. A block whose data the cache must hold is kept only in a data-capable way.

Requests enter through a valid/ready port. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold the request fields stable until that edge. The only back-pressure is `req_ready`. It is low only while the controller empties ways that have just become data-less. The response port and the memory writeback port have no ready signal. Each of their results is a single-cycle `*_valid` pulse that the surrounding logic must take when it appears.

There are three request types. A fill places a block according to its coherence state. A read reports a hit, and returns either data or a forward-to-owner indication. A writeback from a private cache either updates a block in place or moves it from a data-less way into a data-capable way of the set. Replacement is least-recently-used inside each way class. Reads that hit, fills and writebacks count as uses.

Top module: `dlw_set_ctrl`

## Requirements
- R1: After reset, every way is invalid, `req_ready` is 1, and `rsp_valid` and `mem_wb_valid` are 0.
- R2: Ways 0 and 1 are always data-less. Ways 2 to 1+n are also data-less, where n is `dis_cnt` limited to 13. All other ways are data-capable, so at least way 15 always has data storage.
- R3: A fill (`req_op`=1) with `req_excl`=1 stores the tag as exclusively owned in the data-less class. It takes the lowest-numbered invalid way of that class, or else the class's least recently used way. It never disturbs a data-capable way. `rsp_way` gives the way chosen.
- R4: A fill with `req_excl`=0 stores the tag and `req_data` as shared-clean in the data-capable class, choosing the way as in R3. If the replaced block is dirty, `mem_wb_valid` pulses with its tag and data in the same cycle as the response.
- R5: A read (`req_op`=0) that hits a shared or dirty block returns `rsp_hit`=1, `rsp_fwd`=0 and the stored data. A read that hits an exclusively owned block returns `rsp_hit`=1, `rsp_fwd`=1 and zero data. A miss returns `rsp_hit`=0.
- R6: A writeback (`req_op`=2) that hits a data-capable way stores `req_data` in that way, marks the block dirty, and reports that way.
- R7: A writeback that hits a data-less way moves the block, with `req_data`, into a dirty entry of a data-capable way chosen as in R4, including the writeback of a dirty victim. The old entry becomes invalid, and `rsp_way` gives the new way.
- R8: A writeback that misses returns `rsp_hit`=0 and changes no entry.
- R9: Within each class, the way replaced is the one used least recently.
- R10: When `dis_cnt` rises, `req_ready` drops in the same cycle while any newly data-less way holds a shared or dirty block. These ways are emptied one per cycle, lowest-numbered first. Dirty ones pulse `mem_wb_valid` with their tag and data, and shared ones are dropped without a pulse. Exclusively owned entries keep their tag.
- R11: `rsp_valid` pulses in the cycle after the accepting edge. `req_op`=3 is a no-op that still responds, with `rsp_hit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dis_cnt | input | 4 | Number of runtime data-less ways |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 read, 1 fill, 2 writeback, 3 no-op |
| req_tag | input | 12 | Block tag |
| req_excl | input | 1 | Fill state: 1 exclusively owned, 0 shared |
| req_data | input | 16 | Fill or writeback data |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Tag found |
| rsp_fwd | output | 1 | Data lives with the owner cache |
| rsp_way | output | 4 | Way used |
| rsp_data | output | 16 | Read data |
| mem_wb_valid | output | 1 | Memory writeback pulse |
| mem_wb_tag | output | 12 | Tag written back |
| mem_wb_data | output | 16 | Data written back |

## Verification
Every response and every writeback caused by a request is due in the cycle after the rising edge that accepts the request. A drain writeback is due in the cycle after the edge on which its way is emptied. `req_ready` reacts within the same cycle that `dis_cnt` changes. The bench drives inputs on falling edges and samples results on the falling edge that follows the accepting edge. A monitor logs every writeback pulse on falling edges, and the bench reads its counts 1 ns later so that the log is complete. After a count change, the bench checks `req_ready` 1 ns after the new value is applied, then waits for `req_ready` to return before it checks the logged writebacks.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_FILL  = 2'd1,
    OP_WBACK = 2'd2,
    OP_IDLE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_INV = 2'd0,   // no block
    ST_OWN = 2'd1,   // data held by a private owner
    ST_SHR = 2'd2,   // clean data held here
    ST_DRT = 2'd3    // dirty data held here
  } st_e;
endpackage

// File: rtl/dlw_lru.sv
module dlw_lru #(
  parameter int WAYS = 16,
  parameter int AW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_i,
  input  logic [AW-1:0] way_i,
  output logic [AW-1:0] age_o [WAYS]
);
  // Age rank: 0 is most recent. The ranks stay a permutation of 0..WAYS-1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) age_o[w] <= AW'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (AW'(w) == way_i) age_o[w] <= '0;
        else if (age_o[w] < age_o[way_i]) age_o[w] <= age_o[w] + 1'b1;
      end
    end
  end

  assert_touch_mru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    touch_i |=> age_o[$past(way_i)] == '0);
endmodule

// File: rtl/dlw_pick.sv
module dlw_pick #(
  parameter int WAYS = 16,
  parameter int AW   = 4
) (
  input  logic [WAYS-1:0] cls_i,
  input  logic [WAYS-1:0] live_i,
  input  logic [AW-1:0]   age_i [WAYS],
  output logic [AW-1:0]   way_o
);
  logic [AW-1:0] free_way, old_way, old_age;
  logic          have_free, have_old;

  always_comb begin
    free_way  = '0;
    old_way   = '0;
    old_age   = '0;
    have_free = 1'b0;
    have_old  = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (cls_i[w] && !live_i[w]) begin
        have_free = 1'b1;
        free_way  = AW'(w);
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (cls_i[w] && (!have_old || age_i[w] > old_age)) begin
        have_old = 1'b1;
        old_age  = age_i[w];
        old_way  = AW'(w);
      end
    end
    way_o = have_free ? free_way : old_way;
  end
endmodule

// File: rtl/dlw_data.sv
module dlw_data #(
  parameter int WAYS  = 16,
  parameter int FIRST = 2,
  parameter int DW    = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] wway_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] rway_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] rway_b_i,
  output logic [DW-1:0] rdata_b_o
);
  localparam int N = WAYS - FIRST;

  logic [DW-1:0] cells [N];

  // Storage exists only for the ways that can hold data.
  for (genvar g = 0; g < N; g++) begin : g_cell
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (we_i && wway_i == AW'(g + FIRST)) q <= wdata_i;
    end
    assign cells[g] = q;
  end

  always_comb begin
    rdata_a_o = '0;
    rdata_b_o = '0;
    for (int g = 0; g < N; g++) begin
      if (rway_a_i == AW'(g + FIRST)) rdata_a_o = cells[g];
      if (rway_b_i == AW'(g + FIRST)) rdata_b_o = cells[g];
    end
  end
endmodule

// File: rtl/dlw_set_ctrl.sv
module dlw_set_ctrl
  import dlw_pkg::*;
#(
  parameter int WAYS     = 16,
  parameter int FIXED_DL = 2,
  parameter int TAG_W    = 12,
  parameter int DATA_W   = 16,
  localparam int AW      = $clog2(WAYS),
  localparam int CNT_W   = $clog2(WAYS - FIXED_DL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  dis_cnt,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              req_excl,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fwd,
  output logic [AW-1:0]     rsp_way,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_wb_valid,
  output logic [TAG_W-1:0]  mem_wb_tag,
  output logic [DATA_W-1:0] mem_wb_data
);
  localparam int LW      = AW + 1;
  localparam int MAX_OFF = WAYS - FIXED_DL - 1;

  st_e              st_q  [WAYS];
  logic [TAG_W-1:0] tag_q [WAYS];
  logic [AW-1:0]    age   [WAYS];

  op_e              op;
  logic [CNT_W-1:0] off_eff;
  logic [LW-1:0]    dl_lim;
  logic [WAYS-1:0]  is_dl, is_dc, live, hit_vec, drain_vec;
  logic             hit, drain_any, accept;
  logic [AW-1:0]    hit_way, drain_way, dl_pick, dc_pick, rway_b;
  logic [DATA_W-1:0] rdata_a, rdata_b;

  // Next-cycle actions.
  logic              wr_en, clr_en, dwe, touch_en, wb_fire;
  logic [AW-1:0]     wr_way, clr_way, touch_way;
  st_e               wr_st;
  logic              n_hit, n_fwd;
  logic [AW-1:0]     n_way;
  logic [DATA_W-1:0] n_data;

  assign op      = op_e'(req_op);
  assign off_eff = (dis_cnt > CNT_W'(MAX_OFF)) ? CNT_W'(MAX_OFF) : dis_cnt;
  assign dl_lim  = LW'(FIXED_DL) + LW'(off_eff);

  always_comb begin
    hit = 1'b0;
    hit_way = '0;
    drain_any = 1'b0;
    drain_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      is_dl[w]     = LW'(w) < dl_lim;
      is_dc[w]     = !is_dl[w];
      live[w]      = st_q[w] != ST_INV;
      hit_vec[w]   = live[w] && tag_q[w] == req_tag;
      drain_vec[w] = is_dl[w] && (st_q[w] == ST_SHR || st_q[w] == ST_DRT);
      if (hit_vec[w]) begin
        hit = 1'b1;
        hit_way = AW'(w);
      end
      if (drain_vec[w]) begin
        drain_any = 1'b1;
        drain_way = AW'(w);
      end
    end
  end

  assign req_ready = !drain_any;
  assign accept    = req_valid && req_ready;
  assign rway_b    = drain_any ? drain_way : dc_pick;

  dlw_lru #(.WAYS(WAYS), .AW(AW)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_i(touch_en), .way_i(touch_way), .age_o(age));

  dlw_pick #(.WAYS(WAYS), .AW(AW)) u_pick_dl (
    .cls_i(is_dl), .live_i(live), .age_i(age), .way_o(dl_pick));

  dlw_pick #(.WAYS(WAYS), .AW(AW)) u_pick_dc (
    .cls_i(is_dc), .live_i(live), .age_i(age), .way_o(dc_pick));

  dlw_data #(.WAYS(WAYS), .FIRST(FIXED_DL), .DW(DATA_W), .AW(AW)) u_data (
    .clk(clk), .we_i(dwe), .wway_i(wr_way), .wdata_i(req_data),
    .rway_a_i(hit_way), .rdata_a_o(rdata_a), .rway_b_i(rway_b), .rdata_b_o(rdata_b));

  always_comb begin
    wr_en = 1'b0; wr_way = '0; wr_st = ST_INV; dwe = 1'b0;
    clr_en = 1'b0; clr_way = '0;
    touch_en = 1'b0; touch_way = '0; wb_fire = 1'b0;
    n_hit = 1'b0; n_fwd = 1'b0; n_way = '0; n_data = '0;
    if (drain_any) begin
      clr_en  = 1'b1;
      clr_way = drain_way;
      wb_fire = st_q[drain_way] == ST_DRT;
    end else if (accept) begin
      unique case (op)
        OP_READ: begin
          n_hit = hit;
          n_way = hit_way;
          if (hit) begin
            touch_en  = 1'b1;
            touch_way = hit_way;
            n_fwd     = st_q[hit_way] == ST_OWN;
            if (st_q[hit_way] == ST_SHR || st_q[hit_way] == ST_DRT) n_data = rdata_a;
          end
        end
        OP_FILL: begin
          wr_en   = 1'b1;
          wr_way  = req_excl ? dl_pick : dc_pick;
          wr_st   = req_excl ? ST_OWN : ST_SHR;
          dwe     = !req_excl;
          wb_fire = !req_excl && st_q[dc_pick] == ST_DRT;
          touch_en = 1'b1;
          touch_way = wr_way;
          n_way   = wr_way;
        end
        OP_WBACK: begin
          if (hit) begin
            n_hit  = 1'b1;
            wr_en  = 1'b1;
            wr_st  = ST_DRT;
            dwe    = 1'b1;
            if (is_dc[hit_way]) begin
              wr_way = hit_way;
            end else begin
              wr_way  = dc_pick;
              wb_fire = st_q[dc_pick] == ST_DRT;
              clr_en  = 1'b1;
              clr_way = hit_way;
            end
            touch_en  = 1'b1;
            touch_way = wr_way;
            n_way     = wr_way;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) begin
        st_q[w]  <= ST_INV;
        tag_q[w] <= '0;
      end
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_fwd <= 1'b0;
      rsp_way <= '0; rsp_data <= '0;
      mem_wb_valid <= 1'b0; mem_wb_tag <= '0; mem_wb_data <= '0;
    end else begin
      if (clr_en) st_q[clr_way] <= ST_INV;
      if (wr_en) begin
        st_q[wr_way]  <= wr_st;
        tag_q[wr_way] <= req_tag;
      end
      rsp_valid <= accept;
      if (accept) begin
        rsp_hit  <= n_hit;
        rsp_fwd  <= n_fwd;
        rsp_way  <= n_way;
        rsp_data <= n_data;
      end
      mem_wb_valid <= wb_fire;
      if (wb_fire) begin
        mem_wb_tag  <= tag_q[rway_b];
        mem_wb_data <= rdata_b;
      end
    end
  end

  for (genvar g = 0; g < FIXED_DL; g++) begin : g_fixed_chk
    assert_fixed_ways_dataless_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_q[g] == ST_SHR || st_q[g] == ST_DRT));
  end

  assert_rsp_follows_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready));

  assert_fwd_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fwd) |-> (rsp_hit && rsp_data == '0));

  assert_move_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_WBACK && hit && is_dl[hit_way]) |=> st_q[$past(hit_way)] == ST_INV);

  assert_drain_progress_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $stable(dis_cnt)) |-> $countones(drain_vec) < $past($countones(drain_vec)) || $past(req_ready) || !$stable(dis_cnt));
endmodule

// File: tb/dlw_set_ctrl_test.sv
`timescale 1ns/1ps
module dlw_set_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  dis_cnt = '0;
  logic        req_valid = 1'b0, req_ready, req_excl = 1'b0;
  logic [1:0]  req_op = '0;
  logic [11:0] req_tag = '0;
  logic [15:0] req_data = '0;
  logic        rsp_valid, rsp_hit, rsp_fwd, mem_wb_valid;
  logic [3:0]  rsp_way;
  logic [15:0] rsp_data, mem_wb_data;
  logic [11:0] mem_wb_tag;

  int n_cmp = 0, n_bad = 0, wbn = 0;
  logic [11:0] wb_tag_log [8];
  logic [15:0] wb_dat_log [8];
  logic [11:0] tag_at [16];
  logic        r_valid, r_hit, r_fwd;
  logic [3:0]  r_way;
  logic [15:0] r_data;

  always #2.5 clk = ~clk;

  dlw_set_ctrl uut (
    .clk(clk), .rst_n(rst_n), .dis_cnt(dis_cnt),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_tag(req_tag), .req_excl(req_excl), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fwd(rsp_fwd),
    .rsp_way(rsp_way), .rsp_data(rsp_data),
    .mem_wb_valid(mem_wb_valid), .mem_wb_tag(mem_wb_tag), .mem_wb_data(mem_wb_data));

  always @(negedge clk) begin
    if (rst_n && mem_wb_valid) begin
      if (wbn < 8) begin
        wb_tag_log[wbn] = mem_wb_tag;
        wb_dat_log[wbn] = mem_wb_data;
      end
      wbn++;
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [11:0] tag,
                      input logic excl, input logic [15:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_tag = tag; req_excl = excl; req_data = data;
    #0.1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    #1;
    req_valid = 1'b0;
    r_valid = rsp_valid; r_hit = rsp_hit; r_fwd = rsp_fwd; r_way = rsp_way; r_data = rsp_data;
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 ready", req_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 mem_wb_valid", mem_wb_valid, 0);

    send(0, 12'h100, 0, 0);
    check("R11 rsp_valid", r_valid, 1);
    check("R5 miss", r_hit, 0);
    @(negedge clk);
    check("R11 single pulse", rsp_valid, 0);

    send(1, 12'h200, 1, 0); check("R3 first free dl way", r_way, 0);
    send(1, 12'h201, 1, 0); check("R3 second dl way", r_way, 1);
    tag_at[0] = 12'h200; tag_at[1] = 12'h201;
    for (int i = 0; i < 14; i++) begin
      send(1, 12'h300 + 12'(i), 0, 16'hA000 + 16'(i));
      check("R4 shared fill way", r_way, 32'(2 + i));
      tag_at[2 + i] = 12'h300 + 12'(i);
    end

    send(0, 12'h303, 0, 0);
    check("R5 hit", r_hit, 1); check("R5 way", r_way, 5);
    check("R5 data", r_data, 16'hA003); check("R5 no fwd", r_fwd, 0);
    send(0, 12'h200, 0, 0);
    check("R5 owner hit", r_hit, 1); check("R5 fwd", r_fwd, 1);
    check("R5 owner zero data", r_data, 0); check("R5 owner way", r_way, 0);

    send(1, 12'h202, 1, 0); check("R9 dl lru victim", r_way, 1);
    tag_at[1] = 12'h202;
    send(0, 12'h201, 0, 0); check("R9 evicted tag gone", r_hit, 0);
    send(0, 12'h300, 0, 0); check("R3 dc untouched", r_hit, 1);
    check("R3 no writeback", wbn, 0);

    send(2, 12'h305, 0, 16'hB005);
    check("R6 hit", r_hit, 1); check("R6 way", r_way, 7); check("R6 no wb", wbn, 0);
    send(0, 12'h305, 0, 0); check("R6 data stored", r_data, 16'hB005);

    for (int w = 2; w < 16; w++) if (w != 7) begin
      send(0, tag_at[w], 0, 0);
      check("R9 touch read", r_hit, 1);
    end
    send(1, 12'h400, 0, 16'hC400);
    check("R4 dirty lru victim way", r_way, 7);
    check("R4 wb count", wbn, 1);
    check("R4 wb tag", wb_tag_log[0], 12'h305);
    check("R4 wb data", wb_dat_log[0], 16'hB005);
    tag_at[7] = 12'h400;

    send(2, 12'h200, 0, 16'hB200);
    check("R7 hit", r_hit, 1); check("R7 new way", r_way, 2); check("R7 clean victim", wbn, 1);
    tag_at[2] = 12'h200;
    send(0, 12'h200, 0, 0);
    check("R7 moved way", r_way, 2); check("R7 moved no fwd", r_fwd, 0);
    check("R7 moved data", r_data, 16'hB200);
    send(0, 12'h300, 0, 0); check("R7 victim gone", r_hit, 0);
    send(1, 12'h203, 1, 0); check("R7 old entry freed", r_way, 0);
    tag_at[0] = 12'h203;

    send(2, 12'h301, 0, 16'hB301); check("R6 in place", r_way, 3);
    for (int w = 2; w < 16; w++) if (w != 3) begin
      send(0, tag_at[w], 0, 0);
      check("R9 touch read", r_hit, 1);
    end
    send(2, 12'h202, 0, 16'hB202);
    check("R7 move onto dirty victim", r_way, 3);
    check("R7 wb count", wbn, 2);
    check("R7 wb tag", wb_tag_log[1], 12'h301);
    check("R7 wb data", wb_dat_log[1], 16'hB301);

    send(2, 12'h999, 0, 16'h1234);
    check("R8 miss", r_hit, 0); check("R8 no wb", wbn, 2);
    send(0, 12'h999, 0, 0); check("R8 not installed", r_hit, 0);
    send(3, 12'h202, 0, 0);
    check("R11 noop responds", r_valid, 1); check("R11 noop no hit", r_hit, 0);

    @(negedge clk); dis_cnt = 4'd4; #1;
    check("R10 ready drops", req_ready, 0);
    wait_ready();
    check("R10 dirty drained", wbn, 4);
    check("R10 order first", wb_tag_log[2], 12'h200);
    check("R10 order second", wb_tag_log[3], 12'h202);
    check("R10 drained data", wb_dat_log[3], 16'hB202);
    send(0, 12'h200, 0, 0); check("R10 dirty dropped", r_hit, 0);
    send(0, 12'h302, 0, 0); check("R10 shared dropped", r_hit, 0);
    send(1, 12'h205, 1, 0); check("R2 free fixed way", r_way, 1);
    send(1, 12'h206, 1, 0); check("R2 runtime dl way", r_way, 2);

    @(negedge clk); dis_cnt = 4'd0; #1;
    check("R10 ready on decrease", req_ready, 1);
    send(0, 12'h206, 0, 0); check("R10 owner in dc way", r_fwd, 1);
    @(negedge clk); dis_cnt = 4'd1; #1;
    check("R10 owner needs no drain", req_ready, 1);
    send(0, 12'h206, 0, 0); check("R10 owner tag kept", r_way, 2);

    @(negedge clk); dis_cnt = 4'd15; #1;
    wait_ready();
    check("R10 shared drain silent", wbn, 4);
    send(1, 12'h500, 0, 16'hC500); check("R2 clamp keeps way 15", r_way, 15);
    send(1, 12'h501, 0, 16'hC501); check("R2 only way 15", r_way, 15);
    send(0, 12'h501, 0, 0); check("R2 data in way 15", r_data, 16'hC501);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule